// File: doc/BRIEF.md
# Low-Power Auto-Reload Event Timer

This peripheral produces wake-up events for processors. A 16-bit up-counter advances once per prescaled tick. The prescaler divides the input clock by 2^N, with N from 0 to 7. When the counter reaches the programmed reload value on a tick, a sticky match flag is raised and the counter goes back to zero. The interrupt line follows that flag while the match interrupt is enabled. Software programs and controls the timer through six word registers on a simple bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

A four-state machine controls the timer:

| State | Meaning |
|---|---|
| OFF | Timer disabled. |
| ARMED | Timer enabled but not counting. |
| ONCE | Counting to a single match. |
| LOOP | Counting and repeating without end. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| *power-up* | OFF | ARMED | A control write with the run bit set. |
| *shutdown* | any enabled state | OFF | A control write with the run bit clear. The counter and prescaler return to zero. |
| *fire-once* | any enabled state | ONCE | A control write carrying the single-shot start. |
| *fire-loop* | any enabled state | LOOP | A control write carrying the continuous start. |
| *expire* | ONCE | ARMED | Taken on the match. |

The fire-once and fire-loop transitions both restart the counter and prescaler from zero. The enable state gates the register writes. The configuration and interrupt-enable registers accept writes only in OFF. The reload register accepts writes only outside OFF.

Top module: `lp_event_timer`

## Requirements
- R1: After reset the timer is in OFF and `irq` is low. The registers then read as follows:
  - Control, offset 0: 0.
  - Configuration, offset 1: 0.
  - Interrupt enable, offset 2: 0.
  - Status, offset 3: 0.
  - Reload, offset 5: 1.
- R2: The prescaler code is bits [11:9] of the configuration register at offset 1. After a start, the first match sets the flag (reload+1)·2^code clock edges after the edge that applied the start.
- R3: A write to the configuration register (offset 1) is applied only in OFF. In any other state it is dropped.
- R4: A write to the interrupt-enable register (bit 0 at offset 2) is applied only in OFF. In any other state it is dropped.
- R5: A write to the reload register (bits [15:0] at offset 5) is applied only outside OFF. A write of zero is always dropped.
- R6: The control register (offset 0) has three bits:
  - bit 0 is run; it reads back as 1 outside OFF.
  - bit 1 is the single-shot start.
  - bit 2 is the continuous start.

  The start bits always read back as 0. A start is ignored in OFF. When both start bits are set, the continuous start wins.
- R7: In ONCE, the first match sets the flag and moves the timer to ARMED. No further match follows until the next start.
- R8: In LOOP, the counter restarts from zero at each match. The match recurs every (reload+1)·2^code clocks.
- R9: The match flag is bit 0 of the status register at offset 3. Writing 1 to bit 0 of the write-only clear register at offset 4 clears it. If a match and a clear fall on the same edge, the flag stays set. Offset 4 reads as 0.
- R10: `irq` is high exactly while both the match flag and the interrupt enable are 1.
- R11: A control write with run = 0 stops the timer and zeroes the counter and prescaler. The reload value, the configuration and the flag keep their values.
- R12: If the reload value is lowered below the current count while counting, the next tick produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_addr | input | ADDR_W | Word register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Match interrupt |

## Verification
The bench builds the timer with its default parameters: a 16-bit counter, a 3-bit prescaler code at bit 9, and 32-bit data. This puts every division ratio from 1 to 128 within reach, up to the /128 ratio with a short reload. Small reload values make single-shot expiry, continuous repetition, a match colliding with a clear, and a lowered reload happen within a few hundred cycles. The full 16-bit count range is left to the reload-lowering and wrap logic, which holds for any width.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_ONCE  = 2'd2,
        ST_LOOP  = 2'd3
    } lpt_state_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_CFG    = 1;
    localparam int unsigned REG_IEN    = 2;
    localparam int unsigned REG_STAT   = 3;
    localparam int unsigned REG_CLR    = 4;
    localparam int unsigned REG_RELOAD = 5;
    localparam int unsigned REG_COUNT  = 6;

    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_ONCE = 1;
    localparam int unsigned BIT_LOOP = 2;

    typedef struct packed {
        logic we;
        logic run;
        logic go_once;
        logic go_loop;
    } lpt_cmd_t;

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             counting,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;
    localparam logic [DIV_W-1:0] ONES = '1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last;

    // last value of the divider for ratio 2^code
    assign last = ~(ONES << code);
    assign tick = counting && (div_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear) begin
            div_q <= '0;
        end else if (counting) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             match
);
    logic [CNT_W-1:0] cnt_q;

    // reaching or passing the reload value ends the period
    assign match = tick && !clear && (cnt_q >= reload);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= match ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lpt_fsm.sv
module lpt_fsm
    import lpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpt_cmd_t   cmd,
    input  logic       match,
    output lpt_state_e state,
    output logic       enabled,
    output logic       counting,
    output logic       restart
);
    lpt_state_e state_d;
    logic       stop_req;
    logic       start_req;

    assign stop_req  = cmd.we && !cmd.run;
    assign start_req = cmd.we && cmd.run && (cmd.go_once || cmd.go_loop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF: begin
                if (cmd.we && cmd.run) begin
                    state_d = ST_ARMED;              // power-up
                end
            end
            ST_ARMED, ST_ONCE, ST_LOOP: begin
                if (stop_req) begin
                    state_d = ST_OFF;                // shutdown
                end else if (start_req && cmd.go_loop) begin
                    state_d = ST_LOOP;               // fire-loop
                end else if (start_req) begin
                    state_d = ST_ONCE;               // fire-once
                end else if (state == ST_ONCE && match) begin
                    state_d = ST_ARMED;              // expire
                end
            end
        endcase
    end

    always_comb begin
        enabled  = 1'b0;
        counting = 1'b0;
        restart  = 1'b0;
        unique case (state)
            ST_OFF: begin
                enabled = 1'b0;
            end
            ST_ARMED: begin
                enabled = 1'b1;
                restart = stop_req || start_req;
            end
            ST_ONCE, ST_LOOP: begin
                enabled  = 1'b1;
                counting = 1'b1;
                restart  = stop_req || start_req;
            end
        endcase
    end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 16,
    parameter int PSC_W      = 3,
    parameter int PSC_LSB    = 9,
    parameter int RELOAD_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              enabled,
    input  logic              match,
    output lpt_cmd_t          cmd,
    output logic [DATA_W-1:0] rdata,
    output logic [PSC_W-1:0]  psc_code,
    output logic              ie,
    output logic              flag,
    output logic [CNT_W-1:0]  reload
);
    localparam int NREG = REG_COUNT;

    logic [NREG-1:0] hit;
    logic            unused_wdata;

    for (genvar i = 0; i < NREG; i++) begin : g_dec
        assign hit[i] = wr_en && (addr == ADDR_W'(i));
    end

    assign unused_wdata = ^wdata;

    assign cmd.we      = hit[REG_CTRL];
    assign cmd.run     = wdata[BIT_RUN];
    assign cmd.go_once = wdata[BIT_ONCE];
    assign cmd.go_loop = wdata[BIT_LOOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_code <= '0;
            ie       <= 1'b0;
            reload   <= CNT_W'(RELOAD_RST);
            flag     <= 1'b0;
        end else begin
            if (hit[REG_CFG] && !enabled) begin
                psc_code <= wdata[PSC_LSB +: PSC_W];
            end
            if (hit[REG_IEN] && !enabled) begin
                ie <= wdata[0];
            end
            if (hit[REG_RELOAD] && enabled && (wdata[CNT_W-1:0] != '0)) begin
                reload <= wdata[CNT_W-1:0];
            end
            if (match) begin
                flag <= 1'b1;
            end else if (hit[REG_CLR] && wdata[0]) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(REG_CTRL):   rdata[BIT_RUN] = enabled;
            ADDR_W'(REG_CFG):    rdata[PSC_LSB +: PSC_W] = psc_code;
            ADDR_W'(REG_IEN):    rdata[0] = ie;
            ADDR_W'(REG_STAT):   rdata[0] = flag;
            ADDR_W'(REG_RELOAD): rdata[CNT_W-1:0] = reload;
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/lp_event_timer.sv
module lp_event_timer
    import lpt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int CNT_W      = 16,
    parameter int PSC_W      = 3,
    parameter int PSC_LSB    = 9,
    parameter int RELOAD_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    lpt_cmd_t         cmd;
    lpt_state_e       state;
    logic             enabled;
    logic             counting;
    logic             restart;
    logic             tick;
    logic             match;
    logic [PSC_W-1:0] psc_code;
    logic             ie;
    logic             flag;
    logic [CNT_W-1:0] reload;

    lpt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PSC_W(PSC_W), .PSC_LSB(PSC_LSB), .RELOAD_RST(RELOAD_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .enabled(enabled), .match(match), .cmd(cmd),
        .rdata(bus_rdata), .psc_code(psc_code), .ie(ie), .flag(flag),
        .reload(reload)
    );

    lpt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .match(match), .state(state),
        .enabled(enabled), .counting(counting), .restart(restart)
    );

    lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clear(restart), .counting(counting),
        .code(psc_code), .tick(tick)
    );

    lpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(restart), .tick(tick),
        .reload(reload), .match(match)
    );

    assign irq = flag & ie;
endmodule

// File: rtl/lp_event_timer_chk.sv
module lp_event_timer_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input lpt_state_e       state,
    input logic             enabled,
    input logic             match,
    input logic             flag,
    input logic             ie,
    input logic [PSC_W-1:0] psc_code,
    input logic [CNT_W-1:0] reload
);
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enabled) |-> $stable(psc_code));

    assert_ien_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enabled) |-> $stable(ie));

    assert_reload_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enabled) |-> $stable(reload));

    assert_once_expires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ONCE && match) |=> (state == ST_ARMED));

    assert_loop_persists_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOP && match) |=> (state == ST_LOOP));

    assert_match_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    assert_off_no_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF || state == ST_ARMED) |-> !match);
endmodule

bind lp_event_timer lp_event_timer_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .enabled(enabled), .match(match),
    .flag(flag), .ie(ie), .psc_code(psc_code), .reload(reload)
);

// File: tb/lp_event_timer_tb.sv
module lp_event_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    cmp_en = 1'b0;

    // behavioural reference model
    int m_st, m_psc, m_cnt, m_rel, m_code;
    bit m_ie, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_event_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return {31'd0, m_st != 0};
            3'd1:    return 32'(m_code) << 9;
            3'd2:    return {31'd0, m_ie};
            3'd3:    return {31'd0, m_flag};
            3'd5:    return 32'(m_rel);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        int  nst, mask;
        bit  cw, en, cnting, tick, rs, mt;
        if (!rst_n) begin
            m_st = 0; m_psc = 0; m_cnt = 0; m_rel = 1; m_code = 0; m_ie = 0; m_flag = 0;
        end else begin
            cw     = bus_wr && bus_addr == 3'd0;
            en     = (m_st != 0);
            cnting = (m_st >= 2);
            mask   = (1 << m_code) - 1;
            tick   = cnting && (m_psc == mask);
            nst    = m_st;
            rs     = 0;
            if (m_st == 0) begin
                if (cw && bus_wdata[0]) nst = 1;
            end else if (cw && !bus_wdata[0]) begin
                nst = 0; rs = 1;
            end else if (cw && bus_wdata[2]) begin
                nst = 3; rs = 1;
            end else if (cw && bus_wdata[1]) begin
                nst = 2; rs = 1;
            end
            mt = tick && !rs && (m_cnt >= m_rel);
            if (m_st == 2 && mt) nst = 1;
            if (rs) begin
                m_cnt = 0; m_psc = 0;
            end else if (cnting) begin
                if (tick) begin
                    m_psc = 0;
                    m_cnt = mt ? 0 : m_cnt + 1;
                end else begin
                    m_psc++;
                end
            end
            if (bus_wr && bus_addr == 3'd1 && !en) m_code = int'((bus_wdata >> 9) & 32'h7);
            if (bus_wr && bus_addr == 3'd2 && !en) m_ie = bus_wdata[0];
            if (bus_wr && bus_addr == 3'd5 && en && bus_wdata[15:0] != 0) m_rel = int'(bus_wdata[15:0]);
            if (mt) m_flag = 1;
            else if (bus_wr && bus_addr == 3'd4 && bus_wdata[0]) m_flag = 0;
            m_st = nst;
        end
        #2;
        if (cmp_en && rst_n) begin
            chk({phase, " irq"}, {31'd0, irq}, {31'd0, m_flag && m_ie});
            chk({phase, " rdata"}, bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #3;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 2000; k++) begin
            @(posedge clk);
            n++;
            #3;
            if (irq) break;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog (all R): got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        rd_chk("R1 status", 3'd3, 32'd0);
        rd_chk("R1 reload", 3'd5, 32'd1);
        rd_chk("R1 ctrl", 3'd0, 32'd0);
        rd_chk("R1 cfg", 3'd1, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        phase = "R5";
        wr(3'd5, 32'd50);
        rd_chk("R5 reload write dropped while off", 3'd5, 32'd1);

        phase = "R3";
        wr(3'd1, 32'd2 << 9);
        rd_chk("R3 cfg written while off", 3'd1, 32'd2 << 9);
        phase = "R4";
        wr(3'd2, 32'd1);
        rd_chk("R4 ien written while off", 3'd2, 32'd1);

        phase = "R6";
        wr(3'd0, 32'd1);
        rd_chk("R6 run reads back", 3'd0, 32'd1);
        phase = "R3";
        wr(3'd1, 32'd5 << 9);
        rd_chk("R3 cfg dropped while on", 3'd1, 32'd2 << 9);
        phase = "R4";
        wr(3'd2, 32'd0);
        rd_chk("R4 ien dropped while on", 3'd2, 32'd1);
        phase = "R5";
        wr(3'd5, 32'd0);
        rd_chk("R5 zero reload dropped", 3'd5, 32'd1);
        wr(3'd5, 32'd3);
        rd_chk("R5 reload written while on", 3'd5, 32'd3);

        // R6 start from OFF is ignored
        phase = "R6";
        wr(3'd0, 32'd0);
        wr(3'd0, 32'd3);
        repeat (40) @(posedge clk);
        rd_chk("R6 start ignored in off", 3'd3, 32'd0);
        rd_chk("R6 start bits read 0", 3'd0, 32'd1);

        // R2 / R7 single shot, code 2, reload 3
        phase = "R7";
        wr(3'd0, 32'd3);
        measure(n);
        chk("R2 first match at (3+1)*4", 32'(n), 32'd16);
        repeat (40) @(posedge clk);
        wr(3'd4, 32'd1);
        repeat (40) @(posedge clk);
        #3;
        chk("R7 no second match", {31'd0, irq}, 32'd0);
        rd_chk("R7 flag stays clear", 3'd3, 32'd0);

        // R8 continuous
        phase = "R8";
        wr(3'd0, 32'd5);
        measure(n);
        chk("R8 first period", 32'(n), 32'd16);
        wr(3'd4, 32'd1);
        measure(n);
        chk("R8 second period", 32'(n), 32'd15);

        // R10 / R11
        phase = "R10";
        repeat (5) @(posedge clk);
        #3;
        chk("R10 irq held", {31'd0, irq}, 32'd1);
        phase = "R11";
        wr(3'd0, 32'd0);
        wr(3'd2, 32'd0);
        rd_chk("R11 flag kept", 3'd3, 32'd1);
        rd_chk("R11 reload kept", 3'd5, 32'd3);
        rd_chk("R11 cfg kept", 3'd1, 32'd2 << 9);
        chk("R10 masked irq", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'd1);
        #3;
        chk("R10 unmasked irq", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'd1);
        #3;
        chk("R10 cleared irq", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'd1);
        wr(3'd0, 32'd3);
        measure(n);
        chk("R11 restart from zero", 32'(n), 32'd16);

        // R2 code 0 and code 7
        phase = "R2";
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd4, 32'd1);
        wr(3'd0, 32'd1);
        wr(3'd5, 32'd9);
        wr(3'd0, 32'd3);
        measure(n);
        chk("R2 code 0 reload 9", 32'(n), 32'd10);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd7 << 9);
        wr(3'd4, 32'd1);
        wr(3'd0, 32'd1);
        wr(3'd5, 32'd2);
        wr(3'd0, 32'd3);
        measure(n);
        chk("R2 code 7 reload 2", 32'(n), 32'd384);

        // R12 lowered reload
        phase = "R12";
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd4, 32'd1);
        wr(3'd0, 32'd1);
        wr(3'd5, 32'd200);
        wr(3'd0, 32'd5);
        repeat (100) @(posedge clk);
        wr(3'd5, 32'd10);
        measure(n);
        chk("R12 match on next tick", 32'(n), 32'd1);

        // R6 both start bits: loop wins
        phase = "R6";
        wr(3'd0, 32'd0);
        wr(3'd4, 32'd1);
        wr(3'd0, 32'd1);
        wr(3'd0, 32'd7);
        measure(n);
        chk("R6 both starts first period", 32'(n), 32'd11);
        wr(3'd4, 32'd1);
        measure(n);
        chk("R6 both starts repeats", 32'(n), 32'd10);

        // R9 clear on the match edge
        phase = "R9";
        wr(3'd4, 32'd1);
        repeat (8) @(negedge clk);
        wr(3'd4, 32'd1);
        rd_chk("R9 set wins over clear", 3'd3, 32'd1);
        rd_chk("R9 clear reads 0", 3'd4, 32'd0);

        // R9 mixed traffic, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_wr   = ($urandom % 4) == 0;
            bus_addr = 3'($urandom_range(0, 5));
            case (bus_addr)
                3'd0:    bus_wdata = {29'd0, 3'($urandom % 8)} | 32'(($urandom % 8) != 0);
                3'd1:    bus_wdata = 32'($urandom_range(0, 3)) << 9;
                3'd5:    bus_wdata = 32'($urandom_range(0, 12));
                default: bus_wdata = $urandom;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule